// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of a flash-controller SPI master from the system clock. One 32-bit configuration word sets it up. The word holds a period field, a high-time field, a low-time field and a source-select bit. Each SCK period lasts a programmable number of system cycles. Within that period, the high part has its own programmable length, so the duty cycle need not be 50%.

The transfer engine holds `run` high for as long as it wants the clock. The generator answers with `sck` and two single-cycle strobes. `sample_stb` marks every rising SCK edge and `shift_stb` marks every falling edge, which is SPI mode 0. When `run` is low, SCK rests low and the phase counter stays cleared. A configuration word can be written at any time. It is staged and only takes effect at a period boundary or while the clock is stopped, so no period is ever cut short or stretched.

Top module: `spi_sck_gen`

## Requirements
- R1: While `rst_n` is low and in the first cycle after its release, `sck`, `sample_stb` and `shift_stb` are 0 and `src_sel` shows the reset source value 0. The reset configuration is period field 1 and high field 0.
- R2: With period field D in bits 17:12 of the configuration word, one SCK period lasts max(D,1)+1 system cycles while `run` stays high.
- R3: With high field H in bits 11:6, SCK is high for the first min(H+1, max(D,1)) cycles of each period and low for the rest. This leaves at least one low cycle in every period.
- R4: `sample_stb` is high for exactly the cycles in which `sck` has just gone from low to high. `shift_stb` is high for exactly the cycles in which `sck` has just gone from high to low while running. The two strobes are never high together.
- R5: When `run` is low at a clock edge, `sck`, `sample_stb` and `shift_stb` are 0 after that edge and the phase counter returns to zero. The next rise of `run` starts a fresh period: SCK and `sample_stb` go high at the first edge that sees `run` high.
- R6: A word written with `cfg_wr` while the clock runs leaves the current period unchanged. It takes effect from the next period boundary on.
- R7: The low-time field in bits 5:0 has no effect on SCK timing. The low time is always the rest of the period.
- R8: Bit 31 of the active configuration appears on `src_sel`. It changes only when the staged word becomes active, which happens at a period boundary or while the clock is stopped.
- R9: A period field of 0 behaves as 1, which gives the fastest clock of two system cycles per period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | High while the transfer engine wants SCK to toggle |
| cfg_wr | input | 1 | Stage `cfg_word` into the pending configuration |
| cfg_word | input | 32 | Configuration: 31 source, 17:12 period, 11:6 high time, 5:0 low time |
| sck | output | 1 | Serial clock, low when idle |
| sample_stb | output | 1 | One-cycle pulse on each SCK rising edge |
| shift_stb | output | 1 | One-cycle pulse on each SCK falling edge |
| src_sel | output | 1 | Clock-source select from the active configuration |

## Verification
The bench builds the block with its default 6-bit fields and reset configuration. At this width every period value from 0 to 63 can be swept, each paired with high-time values at the edges and the middle of the legal range, including values past the clamp. For every pairing it compares three full periods of SCK and both strobes, cycle by cycle, against an arithmetic model. Dedicated runs cover a mid-transfer reconfiguration, a stop and restart, the source bit and the ignored low-time field.

// File: rtl/spick_pkg.sv
// Shared constants and types for the SPI serial clock generator.
// Assumes a 32-bit configuration word with fixed field positions that
// software relies on; only the field width is kept symbolic here.
package spick_pkg;
    localparam int CFG_W   = 32;
    localparam int FLD_W   = 6;
    localparam int SRC_POS = 31;
    localparam int DIV_LSB = 12;
    localparam int HI_LSB  = 6;
    localparam int LO_LSB  = 0;

    // Decoded fields of the configuration that affect timing or output.
    typedef struct packed {
        logic             src;
        logic [FLD_W-1:0] div;
        logic [FLD_W-1:0] hi;
    } spick_cfg_t;
endpackage

// File: rtl/spick_cfg_reg.sv
// Configuration staging for the SCK generator.
// A write lands in a pending register at once. The active copy takes the
// pending value only when load_en is high, which the phase counter raises
// at a period boundary or while idle. This module also turns the active
// fields into the effective period end count and the high length.
// Assumes wr_word uses the field positions in spick_pkg.
module spick_cfg_reg
    import spick_pkg::*;
#(
    parameter int RST_DIV = 1,
    parameter int RST_HI  = 0,
    parameter bit RST_SRC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_word,
    input  logic             load_en,
    output logic [FLD_W-1:0] div_eff,
    output logic [FLD_W:0]   hi_len,
    output logic             src_sel
);
    localparam spick_cfg_t RST_CFG = '{src: RST_SRC,
                                       div: FLD_W'(RST_DIV),
                                       hi:  FLD_W'(RST_HI)};

    spick_cfg_t       pend_q;
    spick_cfg_t       act_q;
    spick_cfg_t       wr_dec;
    logic [FLD_W:0]   hi_p1;
    logic [FLD_W:0]   div_ext;
    logic             cfg_unused;

    // Pick the fields out of the incoming word.
    always_comb begin
        wr_dec.src = wr_word[SRC_POS];
        wr_dec.div = wr_word[DIV_LSB +: FLD_W];
        wr_dec.hi  = wr_word[HI_LSB  +: FLD_W];
    end

    // Reserved bits and the low-time field do not steer the timing.
    assign cfg_unused = ^{wr_word[SRC_POS-1:DIV_LSB+FLD_W], wr_word[LO_LSB +: FLD_W]};

    // Stage each written word in the pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= RST_CFG;
        end else if (wr_en) begin
            pend_q <= wr_dec;
        end
    end

    // Promote pending to active at a period boundary or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= RST_CFG;
        end else if (load_en) begin
            act_q <= pend_q;
        end
    end

    // Effective end count: a period field of zero acts as one.
    always_comb begin
        div_eff = (act_q.div == '0) ? FLD_W'(1) : act_q.div;
    end

    // High length is H+1, clamped so that at least one low cycle remains.
    always_comb begin
        hi_p1   = {1'b0, act_q.hi} + 1'b1;
        div_ext = {1'b0, div_eff};
        hi_len  = (hi_p1 > div_ext) ? div_ext : hi_p1;
    end

    assign src_sel = act_q.src;

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        div_eff != '0);                                             // R9
    AST_HIGH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_len != '0) && (hi_len <= {1'b0, div_eff}));             // R3
endmodule

// File: rtl/spick_phase_ctr.sv
// Phase counter for the SCK generator.
// It counts system cycles inside one SCK period, from 0 up to div_eff, and
// then wraps. It is held at zero while run is low. It flags the period
// boundary and tells the configuration stage when it may load a new word.
// Assumes div_eff is never zero.
module spick_phase_ctr
    import spick_pkg::*;
#(
    parameter int CNT_W = FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] div_eff,
    output logic             act,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap,
    output logic             load_en
);
    // Last cycle of a running period.
    assign wrap    = act && (cnt == div_eff);
    // Configuration may change when idle or at a boundary.
    assign load_en = !act || wrap;

    // Record whether the clock is currently running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act <= 1'b0;
        end else begin
            act <= run;
        end
    end

    // Advance the in-period count, clearing it on start, wrap or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || !act || wrap) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> (cnt <= div_eff));                                  // R2
    AST_IDLE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !act |-> (cnt == '0));                                      // R5
endmodule

// File: rtl/spick_edge_gen.sv
// SCK waveform and strobe generator.
// SCK is registered. It goes high at the start of every period and stays
// high while the in-period count is below hi_len. The strobes are
// registered alongside SCK, so each one lines up with the edge it marks.
// Assumes 1 <= hi_len <= div_eff, which the configuration stage guarantees.
module spick_edge_gen
    import spick_pkg::*;
#(
    parameter int CNT_W = FLD_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             act,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W:0]   hi_len,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb
);
    logic [CNT_W:0] cnt_nxt;
    logic           period_start;

    assign cnt_nxt      = {1'b0, cnt} + 1'b1;
    assign period_start = run && (!act || wrap);

    // Drive SCK: high at period start, falls once the high length is used.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            sck <= 1'b0;
        end else if (period_start) begin
            sck <= 1'b1;
        end else begin
            sck <= (cnt_nxt < hi_len);
        end
    end

    // Pulse the sample strobe together with each SCK rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sample_stb <= 1'b0;
        end else begin
            sample_stb <= period_start;
        end
    end

    // Pulse the shift strobe together with each SCK fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_stb <= 1'b0;
        end else begin
            shift_stb <= run && act && !wrap && (cnt_nxt == hi_len);
        end
    end

    AST_SAMPLE_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_stb |-> (sck && !$past(sck)));                       // R4
    AST_RISE_HAS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> sample_stb);                                 // R4
    AST_SHIFT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        shift_stb |-> (!sck && $past(sck)));                        // R4
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample_stb && shift_stb));                                // R4
endmodule

// File: rtl/spi_sck_gen.sv
// SPI serial clock generator, top level.
// It divides the system clock into a gated SCK with separately programmed
// period and high time, and emits sample and shift strobes in mode 0 for
// the transfer engine. The configuration is staged and applied only at
// period boundaries or while idle.
// Assumes run is synchronous to clk and that cfg_word is valid with cfg_wr.
module spi_sck_gen
    import spick_pkg::*;
#(
    parameter int RST_DIV = 1,
    parameter int RST_HI  = 0,
    parameter bit RST_SRC = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_word,
    output logic             sck,
    output logic             sample_stb,
    output logic             shift_stb,
    output logic             src_sel
);
    logic [FLD_W-1:0] div_eff;
    logic [FLD_W:0]   hi_len;
    logic             act;
    logic [FLD_W-1:0] cnt;
    logic             wrap;
    logic             load_en;

    // Configuration staging and decode.
    spick_cfg_reg #(
        .RST_DIV (RST_DIV),
        .RST_HI  (RST_HI),
        .RST_SRC (RST_SRC)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .wr_word (cfg_word),
        .load_en (load_en),
        .div_eff (div_eff),
        .hi_len  (hi_len),
        .src_sel (src_sel)
    );

    // In-period cycle counter.
    spick_phase_ctr #(
        .CNT_W (FLD_W)
    ) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .div_eff (div_eff),
        .act     (act),
        .cnt     (cnt),
        .wrap    (wrap),
        .load_en (load_en)
    );

    // Waveform and strobes.
    spick_edge_gen #(
        .CNT_W (FLD_W)
    ) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .act        (act),
        .wrap       (wrap),
        .cnt        (cnt),
        .hi_len     (hi_len),
        .sck        (sck),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb)
    );

    AST_PERIOD_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $past(act && !wrap) |-> ($stable(div_eff) && $stable(hi_len))); // R6
    AST_STOPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(run) |-> (!sck && !sample_stb && !shift_stb));       // R5
endmodule

// File: tb/spi_sck_gen_tb.sv
`timescale 1ns/1ps
module spi_sck_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_word = '0;
    logic        sck, sample_stb, shift_stb, src_sel;
    int          n_run = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    spi_sck_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .cfg_wr     (cfg_wr),
        .cfg_word   (cfg_word),
        .sck        (sck),
        .sample_stb (sample_stb),
        .shift_stb  (shift_stb),
        .src_sel    (src_sel)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act_v, input int exp_v);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act_v, exp_v);
        end
    endtask

    // Expected {sck,sample,shift} at cycle j of a run, from R2, R3, R4 and R9.
    function automatic logic [2:0] expv(input int d, input int h, input int j);
        int de, p, hl, m;
        de = (d == 0) ? 1 : d;
        p  = de + 1;
        hl = (h + 1 > de) ? de : h + 1;
        m  = j % p;
        return {m < hl, m == 0, m == hl};
    endfunction

    function automatic logic [31:0] pack(input bit s, input int d, input int h, input int l);
        return {s, 13'b0, 6'(d), 6'(h), 6'(l)};
    endfunction

    // Stage a word while idle and let it become active.
    task automatic wr_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_word = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // Run three periods and compare every cycle against the model.
    task automatic run_wave(input int d, input int h, input int l, input string req);
        int de, bad, bj;
        logic [2:0] a, e, ba, be;
        de = (d == 0) ? 1 : d;
        bad = 0; bj = 0; ba = '0; be = '0;
        wr_cfg(pack(1'b0, d, h, l));
        run = 1'b1;
        for (int j = 0; j < 3 * (de + 1); j++) begin
            @(posedge clk); #1;
            a = {sck, sample_stb, shift_stb};
            e = expv(d, h, j);
            if (a != e) begin
                if (bad == 0) begin bj = j; ba = a; be = e; end
                bad++;
            end
        end
        chk(bad == 0, req, $sformatf("div=%0d hi=%0d lo=%0d cycle %0d {sck,sample,shift}",
            d, h, l, bj), int'(ba), int'(be));
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog: a hung run still ends with the summary.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] a, e;
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        chk({sck, sample_stb, shift_stb} == 3'b000, "R1", "outputs in reset",
            int'({sck, sample_stb, shift_stb}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({sck, sample_stb, shift_stb, src_sel} == 4'b0000, "R1", "outputs after release",
            int'({sck, sample_stb, shift_stb, src_sel}), 0);

        // R1: reset configuration runs at div 1, hi 0
        @(negedge clk);
        run = 1'b1;
        begin
            int bad = 0;
            for (int j = 0; j < 6; j++) begin
                @(posedge clk); #1;
                if ({sck, sample_stb, shift_stb} != expv(1, 0, j)) bad++;
            end
            chk(bad == 0, "R1", "reset config waveform mismatches", bad, 0);
        end
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);

        // R2 R3 R4 R9: sweep every period value with edge and middle high times
        for (int d = 0; d < 64; d++) begin
            int hs[6];
            hs[0] = 0;
            hs[1] = 1;
            hs[2] = ((d + 1) / 2 - 1 < 0) ? 0 : (d + 1) / 2 - 1;
            hs[3] = (d - 1 < 0) ? 0 : d - 1;
            hs[4] = d;
            hs[5] = 63;
            for (int k = 0; k < 6; k++) begin
                run_wave(d, hs[k], (d * 7 + k) & 63, (d == 0) ? "R9" : "R2/R3/R4");
            end
        end

        // R7: low-time field extremes give identical timing
        run_wave(9, 2, 0, "R7");
        run_wave(9, 2, 63, "R7");
        run_wave(9, 2, 1, "R7");

        // R5: stopping mid-period forces quiet outputs
        wr_cfg(pack(1'b0, 7, 3, 0));
        run = 1'b1;
        repeat (5) @(negedge clk);
        run = 1'b0;
        for (int j = 0; j < 3; j++) begin
            @(posedge clk); #1;
            chk({sck, sample_stb, shift_stb} == 3'b000, "R5", "outputs while stopped",
                int'({sck, sample_stb, shift_stb}), 0);
        end
        // R5: restart begins a fresh period
        run_wave(7, 3, 0, "R5");

        // R6 R8: reconfigure while running; change lands on boundary at cycle 12
        wr_cfg(pack(1'b0, 5, 2, 0));
        begin
            int bad = 0;
            run = 1'b1;
            for (int j = 0; j < 24; j++) begin
                cfg_wr = (j == 7);
                if (j == 7) cfg_word = pack(1'b1, 3, 0, 5);
                @(posedge clk); #1;
                a = {sck, sample_stb, shift_stb};
                e = (j < 12) ? expv(5, 2, j) : expv(3, 0, j - 12);
                if (a != e) begin
                    if (bad == 0)
                        chk(1'b0, "R6", $sformatf("cycle %0d {sck,sample,shift}", j),
                            int'(a), int'(e));
                    bad++;
                end
                if (j == 11) chk(src_sel == 1'b0, "R8", "src_sel before boundary", int'(src_sel), 0);
                if (j == 12) chk(src_sel == 1'b1, "R8", "src_sel after boundary", int'(src_sel), 1);
                @(negedge clk);
            end
            cfg_wr = 1'b0;
            run = 1'b0;
            chk(bad == 0, "R6", "mismatching cycles", bad, 0);
        end

        // R8: idle write updates src_sel without running
        wr_cfg(pack(1'b0, 4, 1, 0));
        #1;
        chk(src_sel == 1'b0, "R8", "src_sel after idle write", int'(src_sel), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule